// File: doc/BRIEF.md
# Configuration Access Address Bridge

This block sits between a simple register-style host port and the data window of a PCI Express root port's configuration path. The host issues one configuration read or write at a time. Each request names a bus, device, function, byte offset and access size. The block works out where the request should go and builds the matching 32-bit address word. It then performs the dword access through the window and returns a status and, for reads, the data.

Requests on bus 0 reach the root port's own registers. They go through an indirect address register. Requests on any other bus reach downstream devices through a packed type-1 address word. A sub-word read fetches the aligned dword and shifts the addressed lanes down. A sub-word write fetches the dword, replaces only the addressed lanes and stores it back. While a downstream access is on the window, the error-forwarding enable is held low, so that an unsupported-request completion from an absent function raises no system error.

Top module: `cfg_access_bridge`

## Requirements
- R1: For a request on a non-zero bus, `cfg_addr` is loaded with the bus in bits 27:20, device in bits 19:15, function in bits 14:12, offset bits 11:2 in bits 11:2 and the value 1 in bits 1:0. It holds that value for the rest of the request.
- R2: For an accepted request on bus 0, `ind_addr` is loaded with the byte offset ANDed with 0x1FFC, and the window access is made with `win_down` low.
- R3: A request is rejected when its size code is 3, or when it is on bus 0 and the device or the function is non-zero. A rejected request makes no window access and answers with status 1 (no device) and read data 0xFFFFFFFF.
- R4: With `INTERNAL_EP` set to 1, a request on a non-zero bus with a non-zero device is rejected as in R3. Device 0 on such a bus is served normally.
- R5: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Read data is the fetched dword shifted right by 8 × (offset mod 4) and masked to the size.
- R6: A 1- or 2-byte write makes exactly one window read and then one window write. The written dword keeps every byte lane outside the addressed ones. The read strobe and the write strobe are never high together.
- R7: A 4-byte write makes one window write of the host data and no window read.
- R8: `err_fwd_en` resets to 1. It is 0 during every window cycle of a downstream request, 1 during root-port window cycles, and back to 1 when the response is given.
- R9: `busy` is high from the cycle after a request is accepted until the response. Requests presented while busy are ignored. `rsp_valid` is a one-cycle pulse.
- R10: A served request answers with status 0. A served write returns read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_offset | input | 12 | Byte offset in configuration space |
| req_size | input | 2 | Size code (0/1/2 = 1/2/4 bytes, 3 invalid) |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 1 | 0 = success, 1 = no device |
| rsp_rdata | output | 32 | Read data, right-aligned |
| ind_addr | output | 32 | Root-port indirect address register |
| cfg_addr | output | 32 | Downstream type-1 address register |
| win_down | output | 1 | Window targets downstream data (1) or root data (0) |
| win_rd | output | 1 | Window read strobe |
| win_wr | output | 1 | Window write strobe |
| win_wdata | output | 32 | Window write data |
| win_rdata | input | 32 | Window read data, same cycle as `win_rd` |
| err_fwd_en | output | 1 | Error forwarding enable |

## Verification
The bench builds two copies with the default field widths. The first has `INTERNAL_EP` = 0 and sits on a dword memory model. With it the bench reaches both routes, every size and lane, read-modify-write and full writes, and requests presented while busy. The second has `INTERNAL_EP` = 1 and returns a fixed window word. That makes the single-device rejection on downstream buses visible, which the first copy can never show.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2,
      ST_FIN  = 2'd3
   } cfgb_state_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   localparam logic ST_OK    = 1'b0;
   localparam logic ST_NODEV = 1'b1;

endpackage

// File: rtl/cfgb_route.sv
module cfgb_route #(
   parameter int BUS_W       = 8,
   parameter int DEV_W       = 5,
   parameter int FN_W        = 3,
   parameter int OFF_W       = 12,
   parameter int DATA_W      = 32,
   parameter int INTERNAL_EP = 0
) (
   input  logic [BUS_W-1:0]  bus,
   input  logic [DEV_W-1:0]  dev,
   input  logic [FN_W-1:0]   fn,
   input  logic [OFF_W-1:0]  off,
   input  logic [1:0]        size,
   output logic              down,
   output logic              reject,
   output logic [DATA_W-1:0] ind_word,
   output logic [DATA_W-1:0] cfg_word,
   output logic [1:0]        lane
);
   localparam int FN_LSB  = 12;
   localparam int DEV_LSB = FN_LSB + FN_W;
   localparam int BUS_LSB = DEV_LSB + DEV_W;
   localparam logic [DATA_W-1:0] IND_MASK = DATA_W'(32'h0000_1ffc);
   localparam logic [DATA_W-1:0] REG_MASK = DATA_W'(32'h0000_0ffc);
   localparam logic [DATA_W-1:0] TYPE1    = DATA_W'(1);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("cfgb_route: DATA_W must be 32");
      end
      if (BUS_LSB + BUS_W > DATA_W) begin : g_bad_pack
         $error("cfgb_route: address fields overflow the word");
      end
      if (OFF_W > 12 || OFF_W < 3) begin : g_bad_off
         $error("cfgb_route: OFF_W out of range");
      end
   endgenerate

   logic root_hit;
   logic bad_root_fn;
   logic bad_size;
   logic ep_block;

   assign root_hit    = (bus == '0);
   assign bad_root_fn = root_hit && ((dev != '0) || (fn != '0));
   assign bad_size    = (size == 2'd3);

   generate
      if (INTERNAL_EP != 0) begin : g_single_dev
         assign ep_block = !root_hit && (dev != '0);
      end else begin : g_multi_dev
         assign ep_block = 1'b0;
      end
   endgenerate

   assign down     = !root_hit;
   assign reject   = bad_size || bad_root_fn || ep_block;
   assign ind_word = DATA_W'(off) & IND_MASK;
   assign cfg_word = (DATA_W'(bus) << BUS_LSB) |
                     (DATA_W'(dev) << DEV_LSB) |
                     (DATA_W'(fn)  << FN_LSB)  |
                     (DATA_W'(off) & REG_MASK) |
                     TYPE1;
   assign lane     = off[1:0];

endmodule

// File: rtl/cfgb_lanes.sv
module cfgb_lanes #(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        size,
   input  logic [1:0]        lane,
   input  logic [DATA_W-1:0] rd_word,
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] new_data,
   output logic [DATA_W-1:0] rd_val,
   output logic [DATA_W-1:0] merged
);
   import cfgb_pkg::*;

   localparam int NB = DATA_W / 8;

   generate
      if (NB != 4) begin : g_bad_lanes
         $error("cfgb_lanes: four byte lanes expected");
      end
   endgenerate

   logic [3:0]        nbytes;
   logic [3:0]        lane_end;
   logic [4:0]        sh;
   logic [NB-1:0]     ben;
   logic [DATA_W-1:0] bmask;

   always_comb begin
      case (size)
         SZ_BYTE: nbytes = 4'd1;
         SZ_HALF: nbytes = 4'd2;
         default: nbytes = 4'd4;
      endcase
   end

   assign lane_end = {2'b00, lane} + nbytes;
   assign sh       = {lane, 3'b000};

   generate
      for (genvar b = 0; b < NB; b++) begin : g_lane
         localparam logic [3:0] BI = 4'(b);
         assign ben[b]          = (BI >= {2'b00, lane}) && (BI < lane_end);
         assign bmask[8*b +: 8] = {8{ben[b]}};
      end
   endgenerate

   assign rd_val = (rd_word & bmask) >> sh;
   assign merged = (old_word & ~bmask) | ((new_data << sh) & bmask);

endmodule

// File: rtl/cfgb_seq.sv
module cfgb_seq #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              route_down,
   input  logic              route_reject,
   input  logic [DATA_W-1:0] ind_word,
   input  logic [DATA_W-1:0] cfg_word,
   input  logic [1:0]        route_lane,
   input  logic [DATA_W-1:0] rd_val,
   input  logic [DATA_W-1:0] merged,
   input  logic [DATA_W-1:0] win_rdata,
   output logic [1:0]        size_q,
   output logic [1:0]        lane_q,
   output logic [DATA_W-1:0] dword_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              busy,
   output logic              rsp_valid,
   output logic              rsp_status,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [DATA_W-1:0] ind_addr,
   output logic [DATA_W-1:0] cfg_addr,
   output logic              win_down,
   output logic              win_rd,
   output logic              win_wr,
   output logic [DATA_W-1:0] win_wdata,
   output logic              err_fwd_en
);
   import cfgb_pkg::*;

   cfgb_state_e       st;
   logic              write_q;
   logic              reject_q;
   logic              down_q;
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         write_q    <= 1'b0;
         reject_q   <= 1'b0;
         down_q     <= 1'b0;
         size_q     <= SZ_BYTE;
         lane_q     <= 2'd0;
         wdata_q    <= '0;
         dword_q    <= '0;
         rdata_q    <= '0;
         ind_addr   <= '0;
         cfg_addr   <= '0;
         err_fwd_en <= 1'b1;
         rsp_valid  <= 1'b0;
         rsp_status <= ST_OK;
         rsp_rdata  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  write_q  <= req_write;
                  reject_q <= route_reject;
                  down_q   <= route_down;
                  size_q   <= req_size;
                  lane_q   <= route_lane;
                  wdata_q  <= req_wdata;
                  if (route_reject) begin
                     st <= ST_FIN;
                  end else begin
                     if (route_down) begin
                        cfg_addr   <= cfg_word;
                        err_fwd_en <= 1'b0;
                     end else begin
                        ind_addr <= ind_word;
                     end
                     st <= (req_write && req_size == SZ_WORD) ? ST_WR : ST_RD;
                  end
               end
            end
            ST_RD: begin
               dword_q <= win_rdata;
               rdata_q <= rd_val;
               st      <= write_q ? ST_WR : ST_FIN;
            end
            ST_WR: begin
               st <= ST_FIN;
            end
            default: begin
               rsp_valid  <= 1'b1;
               rsp_status <= reject_q ? ST_NODEV : ST_OK;
               rsp_rdata  <= reject_q ? '1 : (write_q ? '0 : rdata_q);
               err_fwd_en <= 1'b1;
               st         <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy      = (st != ST_IDLE);
   assign win_rd    = (st == ST_RD);
   assign win_wr    = (st == ST_WR);
   assign win_down  = down_q;
   assign win_wdata = (size_q == SZ_WORD) ? wdata_q : merged;

   AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_rd && win_wr)); // R6
   AST_ERR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (win_rd || win_wr) && win_down |-> !err_fwd_en); // R8
   AST_ERR_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> err_fwd_en); // R8
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R9
   AST_REJ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_status |-> rsp_rdata == '1); // R3
   AST_FULL_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
      win_wr && size_q == SZ_WORD |-> !$past(win_rd)); // R7
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(cfg_addr) && $stable(ind_addr)); // R1

endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge #(
   parameter int BUS_W       = 8,
   parameter int DEV_W       = 5,
   parameter int FN_W        = 3,
   parameter int OFF_W       = 12,
   parameter int DATA_W      = 32,
   parameter int INTERNAL_EP = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [BUS_W-1:0]  req_bus,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [FN_W-1:0]   req_func,
   input  logic [OFF_W-1:0]  req_offset,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              rsp_valid,
   output logic              rsp_status,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [DATA_W-1:0] ind_addr,
   output logic [DATA_W-1:0] cfg_addr,
   output logic              win_down,
   output logic              win_rd,
   output logic              win_wr,
   output logic [DATA_W-1:0] win_wdata,
   input  logic [DATA_W-1:0] win_rdata,
   output logic              err_fwd_en
);
   logic              r_down;
   logic              r_reject;
   logic [DATA_W-1:0] r_ind;
   logic [DATA_W-1:0] r_cfg;
   logic [1:0]        r_lane;
   logic [1:0]        size_q;
   logic [1:0]        lane_q;
   logic [DATA_W-1:0] dword_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rd_val;
   logic [DATA_W-1:0] merged;

   cfgb_route #(
      .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W),
      .DATA_W(DATA_W), .INTERNAL_EP(INTERNAL_EP)
   ) u_route (
      .bus(req_bus), .dev(req_dev), .fn(req_func), .off(req_offset),
      .size(req_size), .down(r_down), .reject(r_reject),
      .ind_word(r_ind), .cfg_word(r_cfg), .lane(r_lane)
   );

   cfgb_lanes #(.DATA_W(DATA_W)) u_lanes (
      .size(size_q), .lane(lane_q), .rd_word(win_rdata),
      .old_word(dword_q), .new_data(wdata_q),
      .rd_val(rd_val), .merged(merged)
   );

   cfgb_seq #(.DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_wdata(req_wdata),
      .route_down(r_down), .route_reject(r_reject),
      .ind_word(r_ind), .cfg_word(r_cfg), .route_lane(r_lane),
      .rd_val(rd_val), .merged(merged), .win_rdata(win_rdata),
      .size_q(size_q), .lane_q(lane_q), .dword_q(dword_q), .wdata_q(wdata_q),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
      .rsp_rdata(rsp_rdata), .ind_addr(ind_addr), .cfg_addr(cfg_addr),
      .win_down(win_down), .win_rd(win_rd), .win_wr(win_wr),
      .win_wdata(win_wdata), .err_fwd_en(err_fwd_en)
   );

endmodule

// File: tb/cfg_access_bridge_tb_top.sv
module cfg_access_bridge_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        int_req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_bus = '0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_func = '0;
   logic [11:0] req_offset = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;

   logic        busy, rsp_valid, rsp_status, win_down, win_rd, win_wr, err_fwd_en;
   logic [31:0] rsp_rdata, ind_addr, cfg_addr, win_wdata, win_rdata;

   logic        i_busy, i_rsp_valid, i_rsp_status, i_win_down, i_win_rd, i_win_wr, i_err;
   logic [31:0] i_rsp_rdata, i_ind_addr, i_cfg_addr, i_win_wdata;

   int checks = 0;
   int errors = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   int err_bad = 0;

   logic [31:0] rmem [64];
   logic [31:0] dmem [128];
   logic [5:0]  ridx;
   logic [6:0]  didx;

   always #2 clk = ~clk;

   cfg_access_bridge #(.INTERNAL_EP(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
      .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
      .rsp_rdata(rsp_rdata), .ind_addr(ind_addr), .cfg_addr(cfg_addr),
      .win_down(win_down), .win_rd(win_rd), .win_wr(win_wr),
      .win_wdata(win_wdata), .win_rdata(win_rdata), .err_fwd_en(err_fwd_en)
   );

   cfg_access_bridge #(.INTERNAL_EP(1)) dut_int_i (
      .clk(clk), .rst_n(rst_n), .req_valid(int_req_valid), .req_write(req_write),
      .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
      .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
      .busy(i_busy), .rsp_valid(i_rsp_valid), .rsp_status(i_rsp_status),
      .rsp_rdata(i_rsp_rdata), .ind_addr(i_ind_addr), .cfg_addr(i_cfg_addr),
      .win_down(i_win_down), .win_rd(i_win_rd), .win_wr(i_win_wr),
      .win_wdata(i_win_wdata), .win_rdata(32'h1234_5678), .err_fwd_en(i_err)
   );

   // memory model behind the data window
   assign ridx      = ind_addr[7:2];
   assign didx      = {cfg_addr[16:15], cfg_addr[6:2]};
   assign win_rdata = win_down ? dmem[didx] : rmem[ridx];

   always @(posedge clk) begin
      if (win_wr) begin
         if (win_down) dmem[didx] <= win_wdata;
         else          rmem[ridx] <= win_wdata;
      end
      if (win_rd) rd_cnt++;
      if (win_wr) wr_cnt++;
      if ((win_rd || win_wr) && (win_down == err_fwd_en)) err_bad++;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input logic wr, input logic [7:0] bus, input logic [4:0] dev,
                      input logic [2:0] fn, input logic [11:0] off,
                      input logic [1:0] sz, input logic [31:0] wd);
      @(negedge clk);
      rd_cnt = 0; wr_cnt = 0; err_bad = 0;
      req_write = wr; req_bus = bus; req_dev = dev; req_func = fn;
      req_offset = off; req_size = sz; req_wdata = wd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int n = 0; n < 20 && !rsp_valid; n++) @(negedge clk);
   endtask

   function automatic logic [31:0] pack(input logic [7:0] bus, input logic [4:0] dev,
                                        input logic [2:0] fn, input logic [11:0] off);
      return {4'h0, bus, dev, fn, off[11:2], 2'b01};
   endfunction

   // {wr, bus, dev, fn, off, size, wdata, exp_status, exp_rdata}
   localparam int NV = 13;
   localparam logic [95:0] VEC [NV] = '{
      {1'b0, 8'd0, 5'd0, 3'd0, 12'h010, 2'd2, 32'h0,        1'b0, 32'h4433_2215},
      {1'b0, 8'd0, 5'd0, 3'd0, 12'h011, 2'd0, 32'h0,        1'b0, 32'h0000_0022},
      {1'b0, 8'd0, 5'd0, 3'd0, 12'h012, 2'd1, 32'h0,        1'b0, 32'h0000_4433},
      {1'b1, 8'd0, 5'd0, 3'd0, 12'h013, 2'd0, 32'h0000_00AB, 1'b0, 32'h0},
      {1'b0, 8'd0, 5'd0, 3'd0, 12'h010, 2'd2, 32'h0,        1'b0, 32'hAB33_2215},
      {1'b0, 8'd0, 5'd1, 3'd0, 12'h010, 2'd2, 32'h0,        1'b1, 32'hFFFF_FFFF},
      {1'b0, 8'd0, 5'd0, 3'd2, 12'h010, 2'd2, 32'h0,        1'b1, 32'hFFFF_FFFF},
      {1'b0, 8'd4, 5'd0, 3'd0, 12'h010, 2'd3, 32'h0,        1'b1, 32'hFFFF_FFFF},
      {1'b0, 8'd5, 5'd2, 3'd0, 12'h008, 2'd2, 32'h0,        1'b0, 32'hDDCC_BB42},
      {1'b1, 8'd5, 5'd2, 3'd0, 12'h00A, 2'd1, 32'h0000_1234, 1'b0, 32'h0},
      {1'b0, 8'd5, 5'd2, 3'd0, 12'h008, 2'd2, 32'h0,        1'b0, 32'h1234_BB42},
      {1'b1, 8'd3, 5'd1, 3'd1, 12'h01C, 2'd2, 32'hCAFE_F00D, 1'b0, 32'h0},
      {1'b0, 8'd3, 5'd1, 3'd1, 12'h01D, 2'd0, 32'h0,        1'b0, 32'h0000_00F0}
   };

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++)  rmem[i] = 32'h4433_2211 + 32'(i);
      for (int i = 0; i < 128; i++) dmem[i] = 32'hDDCC_BB00 + 32'(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk(busy == 1'b0 && rsp_valid == 1'b0, "R9 reset idle", {30'b0, busy, rsp_valid}, 32'h0);
      chk(err_fwd_en == 1'b1, "R8 reset enable", {31'b0, err_fwd_en}, 32'h1);
      chk(win_rd == 1'b0 && win_wr == 1'b0, "R6 reset strobes", {30'b0, win_rd, win_wr}, 32'h0);

      // vector table
      for (int v = 0; v < NV; v++) begin
         logic        w, est;
         logic [7:0]  b;
         logic [4:0]  d;
         logic [2:0]  f;
         logic [11:0] o;
         logic [1:0]  s;
         logic [31:0] wd, erd;
         {w, b, d, f, o, s, wd, est, erd} = VEC[v];
         run(w, b, d, f, o, s, wd);
         chk(rsp_valid === 1'b1, "R9 response seen", {31'b0, rsp_valid}, 32'h1);
         chk(rsp_status == est, est ? "R3 reject status" : "R10 ok status",
             {31'b0, rsp_status}, {31'b0, est});
         chk(rsp_rdata == erd, w ? "R10 write data" : (est ? "R3 all ones" : "R5 read data"),
             rsp_rdata, erd);
         if (est) begin
            chk(rd_cnt + wr_cnt == 0, "R3 no window access", 32'(rd_cnt + wr_cnt), 32'h0);
         end else begin
            if (b != 0) chk(cfg_addr == pack(b, d, f, o), "R1 address word", cfg_addr, pack(b, d, f, o));
            else        chk(ind_addr == ({20'h0, o} & 32'h1ffc), "R2 indirect word",
                            ind_addr, {20'h0, o} & 32'h1ffc);
            chk(err_bad == 0, "R8 enable during access", 32'(err_bad), 32'h0);
            chk(err_fwd_en == 1'b1, "R8 enable restored", {31'b0, err_fwd_en}, 32'h1);
            if (w && s == 2'd2)
               chk(rd_cnt == 0 && wr_cnt == 1, "R7 single write", 32'(rd_cnt * 16 + wr_cnt), 32'h1);
            else if (w)
               chk(rd_cnt == 1 && wr_cnt == 1, "R6 read then write", 32'(rd_cnt * 16 + wr_cnt), 32'h11);
         end
      end

      // R9: request held while busy is ignored
      @(negedge clk);
      req_write = 1'b1; req_bus = 8'd0; req_dev = 5'd0; req_func = 3'd0;
      req_offset = 12'h020; req_size = 2'd2; req_wdata = 32'h55AA_55AA; req_valid = 1'b1;
      @(negedge clk);
      chk(busy == 1'b1, "R9 busy after accept", {31'b0, busy}, 32'h1);
      req_offset = 12'h024; req_wdata = 32'hDEAD_BEEF;
      for (int n = 0; n < 20 && !rsp_valid; n++) @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b0, "R9 busy cleared", {31'b0, busy}, 32'h0);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R9 single pulse", {31'b0, rsp_valid}, 32'h0);
      run(1'b0, 8'd0, 5'd0, 3'd0, 12'h024, 2'd2, 32'h0);
      chk(rsp_rdata == 32'h4433_221A, "R9 ignored request", rsp_rdata, 32'h4433_221A);
      run(1'b0, 8'd0, 5'd0, 3'd0, 12'h020, 2'd2, 32'h0);
      chk(rsp_rdata == 32'h55AA_55AA, "R9 accepted request", rsp_rdata, 32'h55AA_55AA);

      // R4: single downstream device variant
      @(negedge clk);
      req_write = 1'b0; req_bus = 8'd2; req_dev = 5'd3; req_func = 3'd0;
      req_offset = 12'h001; req_size = 2'd0; int_req_valid = 1'b1;
      @(negedge clk);
      int_req_valid = 1'b0;
      for (int n = 0; n < 20 && !i_rsp_valid; n++) @(negedge clk);
      chk(i_rsp_status == 1'b1 && i_rsp_rdata == 32'hFFFF_FFFF, "R4 other device rejected",
          i_rsp_rdata, 32'hFFFF_FFFF);
      @(negedge clk);
      req_dev = 5'd0; int_req_valid = 1'b1;
      @(negedge clk);
      int_req_valid = 1'b0;
      for (int n = 0; n < 20 && !i_rsp_valid; n++) @(negedge clk);
      chk(i_rsp_status == 1'b0 && i_rsp_rdata == 32'h0000_0056, "R4 device 0 served",
          i_rsp_rdata, 32'h0000_0056);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule